// File: doc/BRIEF.md
# Low-Power SDRAM Power-Up Sequencer

This block brings a four-bank, 16-bit low-power synchronous DRAM from power-on to a usable state. From reset it holds clock enable high and drives only NOP commands for a settling period. The length of that period is worked out from a clock-frequency parameter and a wait time in microseconds. Once the period ends it issues one precharge to every bank and a programmable number of auto-refresh commands. It then writes the mode register with CAS latency, burst length and burst type. If the chosen drive strength or self-refresh coverage differs from the device's power-on default, it also writes the extended mode register.

After the final register load and its settling gap, the block raises `ready` and keeps it high until the next reset. From then on an upstream controller can ask for a new drive-strength and refresh-coverage setting. The block holds each request and issues the extended-register write only while the controller reports that every bank is idle. It does not repeat the power-up steps for such an update. Command gaps (precharge, refresh and register-load recovery) are parameters given as counts of NOP cycles.

Top module: `lpsd_init_seq`

## Requirements
- R1: While reset is high, and for WAIT = CLK_MHZ*WAIT_US cycles after reset falls, the command pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) and `ready` is 0.
- R2: On cycle WAIT after reset falls, the block issues precharge-all (cs_n,ras_n,cas_n,we_n = 0,0,1,0 with addr[10]=1). TRP_CYC NOP cycles follow it.
- R3: After the precharge gap, exactly NUM_REFRESH auto-refresh commands (0,0,0,1) are issued. Each is followed by TRFC_CYC NOP cycles.
- R4: After the last refresh gap, a mode-register load (0,0,0,0) is issued with ba=2'b00. Its key is addr[2:0] = burst code (1→000, 2→001, 4→010, 8→011, full page→111), addr[3] = 1 for interleaved, addr[6:4] = CAS latency, and all other bits 0.
- R5: After the mode load and TMRD_CYC NOP cycles, an extended-register load is issued with ba=2'b10 only if the init setting is not half drive with full-array refresh. Its key is addr[2:0] = coverage (000 full, 001 half, 010 quarter), addr[6:5] = drive (00 full, 01 half), and all other bits 0. With the default setting this load is skipped.
- R6: `ready` rises on the cycle after the final register-load gap of TMRD_CYC NOPs ends, and stays 1 until reset.
- R7: When `ready` is 1, a request is pending and `banks_idle` is 1, the next cycle carries an extended-register load holding the settings captured with the latest request. The pending request is then cleared.
- R8: A request made while `ready` is 0 does not change the init key. It is held, and while `banks_idle` is 0 no load is issued.
- R9: `cke` is 1 in every cycle, including reset.
- R10: With `ready` high and nothing issuable, the command pins stay at NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| banks_idle | input | 1 | High when the controller has every bank precharged |
| upd_req | input | 1 | Pulse requesting a new extended-register setting |
| upd_drive_half | input | 1 | Requested drive strength, 1 = half |
| upd_pasr | input | 2 | Requested self-refresh coverage, 0 full, 1 half, 2 quarter |
| cke | output | 1 | Clock enable to the DRAM |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address / register select |
| addr | output | 13 | Row address / register key |
| ready | output | 1 | Initialization complete |

## Verification
A wrong state or counter value shows up at once on the command pins. The bench compares all four pins every cycle against a schedule computed from the gap parameters, so a command that comes one cycle early or late, or a missing or extra refresh, fails on that exact cycle. A wrongly built key shows up on `addr` and `ba` in the single cycle of each register load. A lost or early update request shows up as a load that is missing or comes too soon, within one or two cycles of `banks_idle` or the request pulse.

// File: rtl/lpsd_init_pkg.sv
package lpsd_init_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_PRE,
        ST_REF,
        ST_MRS,
        ST_EMRS,
        ST_GAP,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    typedef struct packed {
        logic       drive_half;
        logic [1:0] pasr;
    } ext_cfg_t;

    localparam cmd_pins_t CMD_NOP  = '{1'b0, 1'b1, 1'b1, 1'b1};
    localparam cmd_pins_t CMD_PALL = '{1'b0, 1'b0, 1'b1, 1'b0};
    localparam cmd_pins_t CMD_AREF = '{1'b0, 1'b0, 1'b0, 1'b1};
    localparam cmd_pins_t CMD_LOAD = '{1'b0, 1'b0, 1'b0, 1'b0};

    localparam logic [1:0] BA_MODE = 2'b00;
    localparam logic [1:0] BA_EXT  = 2'b10;

    function automatic logic [2:0] burst_code(int bl);
        case (bl)
            1:       return 3'b000;
            2:       return 3'b001;
            4:       return 3'b010;
            8:       return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    function automatic logic [12:0] mode_key(int cl, int bl, bit interleave);
        logic [12:0] k;
        k      = '0;
        k[2:0] = burst_code(bl);
        k[3]   = interleave;
        k[6:4] = 3'(cl);
        return k;
    endfunction

    function automatic logic [12:0] ext_key(ext_cfg_t c);
        logic [12:0] k;
        k      = '0;
        k[2:0] = {1'b0, c.pasr};
        k[6:5] = {1'b0, c.drive_half};
        return k;
    endfunction

    function automatic logic ext_is_default(ext_cfg_t c);
        return c.drive_half && (c.pasr == 2'd0);
    endfunction

endpackage

// File: rtl/lpsd_gap_timer.sv
module lpsd_gap_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= W'(RST_VAL);
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    assert_load_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/lpsd_ext_pending.sv
module lpsd_ext_pending
    import lpsd_init_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  ext_cfg_t req_cfg,
    input  logic     take,
    output logic     pending,
    output ext_cfg_t held_cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= 1'b0;
            held_cfg <= '0;
        end else if (req) begin
            pending  <= 1'b1;
            held_cfg <= req_cfg;
        end else if (take) begin
            pending  <= 1'b0;
        end
    end

    assert_req_latched_R8: assert property (@(posedge clk) disable iff (rst)
        req |=> (pending && held_cfg == $past(req_cfg)));

endmodule

// File: rtl/lpsd_init_seq.sv
module lpsd_init_seq
    import lpsd_init_pkg::*;
#(
    parameter int CLK_MHZ          = 125,
    parameter int WAIT_US          = 200,
    parameter int NUM_REFRESH      = 2,
    parameter int TRP_CYC          = 3,
    parameter int TRFC_CYC         = 9,
    parameter int TMRD_CYC         = 2,
    parameter int CAS_LAT          = 3,
    parameter int BURST_LEN        = 8,
    parameter bit BURST_INTERLEAVE = 1'b0,
    parameter bit INIT_DRIVE_HALF  = 1'b1,
    parameter int INIT_PASR        = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        banks_idle,
    input  logic        upd_req,
    input  logic        upd_drive_half,
    input  logic [1:0]  upd_pasr,
    output logic        cke,
    output logic        cs_n,
    output logic        ras_n,
    output logic        cas_n,
    output logic        we_n,
    output logic [1:0]  ba,
    output logic [12:0] addr,
    output logic        ready
);
    localparam int       WAIT_CYC  = CLK_MHZ * WAIT_US;
    localparam int       TW        = $clog2(WAIT_CYC + TRP_CYC + TRFC_CYC + TMRD_CYC + 1);
    localparam int       RW        = $clog2(NUM_REFRESH + 1);
    localparam ext_cfg_t INIT_CFG  = '{INIT_DRIVE_HALF, 2'(INIT_PASR)};
    localparam bit       INIT_EXT  = !ext_is_default(INIT_CFG);
    localparam logic [12:0] MKEY   = mode_key(CAS_LAT, BURST_LEN, BURST_INTERLEAVE);

    seq_state_t    state, ret_state;
    logic [RW-1:0] ref_cnt;
    ext_cfg_t      cur_cfg, held_cfg;
    logic          ready_q, pending, take;
    logic          tmr_load, tmr_expired;
    logic [TW-1:0] tmr_val;
    cmd_pins_t     cmd;

    assign take = (state == ST_DONE) && pending && banks_idle;

    lpsd_ext_pending u_pend (
        .clk      (clk),
        .rst      (rst),
        .req      (upd_req),
        .req_cfg  ('{upd_drive_half, upd_pasr}),
        .take     (take),
        .pending  (pending),
        .held_cfg (held_cfg)
    );

    always_comb begin
        tmr_load = 1'b1;
        tmr_val  = '0;
        case (state)
            ST_PRE:          tmr_val = TW'(TRP_CYC - 1);
            ST_REF:          tmr_val = TW'(TRFC_CYC - 1);
            ST_MRS, ST_EMRS: tmr_val = TW'(TMRD_CYC - 1);
            default:         tmr_load = 1'b0;
        endcase
    end

    lpsd_gap_timer #(.W(TW), .RST_VAL(WAIT_CYC - 1)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_WAIT;
            ret_state <= ST_PRE;
            ref_cnt   <= '0;
            cur_cfg   <= INIT_CFG;
            ready_q   <= 1'b0;
        end else begin
            case (state)
                ST_WAIT: if (tmr_expired) state <= ST_PRE;
                ST_PRE: begin
                    state     <= ST_GAP;
                    ret_state <= ST_REF;
                end
                ST_REF: begin
                    ref_cnt   <= ref_cnt + 1'b1;
                    state     <= ST_GAP;
                    ret_state <= (ref_cnt == RW'(NUM_REFRESH - 1)) ? ST_MRS : ST_REF;
                end
                ST_MRS: begin
                    state     <= ST_GAP;
                    ret_state <= INIT_EXT ? ST_EMRS : ST_DONE;
                end
                ST_EMRS: begin
                    state     <= ST_GAP;
                    ret_state <= ST_DONE;
                end
                ST_GAP: if (tmr_expired) begin
                    state <= ret_state;
                    if (ret_state == ST_DONE) ready_q <= 1'b1;
                end
                ST_DONE: if (take) begin
                    state   <= ST_EMRS;
                    cur_cfg <= held_cfg;
                end
                default: state <= ST_WAIT;
            endcase
        end
    end

    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        case (state)
            ST_PRE: begin
                cmd      = CMD_PALL;
                addr[10] = 1'b1;
            end
            ST_REF: cmd = CMD_AREF;
            ST_MRS: begin
                cmd  = CMD_LOAD;
                ba   = BA_MODE;
                addr = MKEY;
            end
            ST_EMRS: begin
                cmd  = CMD_LOAD;
                ba   = BA_EXT;
                addr = ext_key(cur_cfg);
            end
            default: ;
        endcase
    end

    assign cke   = 1'b1;
    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;
    assign ready = ready_q;

    assert_wait_release_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_WAIT && state != ST_WAIT) |-> $past(tmr_expired));

    assert_refresh_count_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MRS) |-> (ref_cnt == RW'(NUM_REFRESH)));

    assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ready_q |=> ready_q);

    assert_update_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EMRS && $past(state) == ST_DONE) |-> ($past(banks_idle) && $past(pending)));

    assert_no_update_before_ready_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EMRS && !ready_q) |-> (cur_cfg == INIT_CFG));

endmodule

// File: tb/lpsd_init_seq_test.sv
`timescale 1ns/1ps
module lpsd_init_seq_test;
    localparam int CLK_MHZ = 125, WAIT_US = 1, TRP = 3, TRFC = 7, TMRD = 2, NREF = 3;
    localparam int W        = CLK_MHZ * WAIT_US;
    localparam int AT_PRE   = W;
    localparam int AT_REF0  = W + 1 + TRP;
    localparam int STEP     = 1 + TRFC;
    localparam int AT_MRS   = AT_REF0 + NREF * STEP;
    localparam int AT_EMRS  = AT_MRS + 1 + TMRD;
    localparam int AT_RDY   = AT_EMRS + 1 + TMRD;
    localparam int AT_RDY_D = AT_MRS + 1 + TMRD;

    logic clk = 1'b0, rst = 1'b1, banks_idle = 1'b0, upd_req = 1'b0, upd_drive_half = 1'b0;
    logic [1:0] upd_pasr = 2'd0;
    logic cke, cs_n, ras_n, cas_n, we_n, ready;
    logic [1:0] ba;
    logic [12:0] addr;
    logic d_cke, d_cs_n, d_ras_n, d_cas_n, d_we_n, d_ready;
    logic [1:0] d_ba;
    logic [12:0] d_addr;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    lpsd_init_seq #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .NUM_REFRESH(NREF), .TRP_CYC(TRP),
        .TRFC_CYC(TRFC), .TMRD_CYC(TMRD), .CAS_LAT(2), .BURST_LEN(4), .BURST_INTERLEAVE(1'b1),
        .INIT_DRIVE_HALF(1'b0), .INIT_PASR(1)) uut (
        .clk(clk), .rst(rst), .banks_idle(banks_idle), .upd_req(upd_req),
        .upd_drive_half(upd_drive_half), .upd_pasr(upd_pasr), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .ready(ready));

    lpsd_init_seq #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .NUM_REFRESH(NREF), .TRP_CYC(TRP),
        .TRFC_CYC(TRFC), .TMRD_CYC(TMRD), .CAS_LAT(2), .BURST_LEN(4), .BURST_INTERLEAVE(1'b1),
        .INIT_DRIVE_HALF(1'b1), .INIT_PASR(0)) uut_dflt (
        .clk(clk), .rst(rst), .banks_idle(1'b0), .upd_req(1'b0),
        .upd_drive_half(1'b0), .upd_pasr(2'd0), .cke(d_cke), .cs_n(d_cs_n),
        .ras_n(d_ras_n), .cas_n(d_cas_n), .we_n(d_we_n), .ba(d_ba), .addr(d_addr), .ready(d_ready));

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] pins();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    function automatic logic [3:0] exp_cmd(int n, bit with_ext);
        if (n == AT_PRE) return 4'b0010;
        if (n >= AT_REF0 && n < AT_MRS && ((n - AT_REF0) % STEP) == 0) return 4'b0001;
        if (n == AT_MRS) return 4'b0000;
        if (with_ext && n == AT_EMRS) return 4'b0000;
        return 4'b0111;
    endfunction

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "cmd in reset", 16'(pins()), 16'h7);
        chk("R1", "ready in reset", 16'(ready), 16'h0);
        chk("R9", "cke in reset", 16'(cke), 16'h1);
    endtask

    task automatic t_power_up();
        rst = 1'b0;
        for (int n = 0; n <= AT_RDY; n++) begin
            if (n > 0) @(negedge clk);
            chk("R1-R5", $sformatf("uut cmd cycle %0d", n), 16'(pins()), 16'(exp_cmd(n, 1'b1)));
            chk("R9", "cke", 16'(cke), 16'h1);
            chk("R6", $sformatf("uut ready cycle %0d", n), 16'(ready), 16'(n >= AT_RDY));
            chk("R5", $sformatf("default cmd cycle %0d", n),
                16'({d_cs_n, d_ras_n, d_cas_n, d_we_n}), 16'(exp_cmd(n, 1'b0)));
            chk("R6", "default ready", 16'(d_ready), 16'(n >= AT_RDY_D));
            if (n == AT_PRE) chk("R2", "precharge-all addr10", 16'(addr[10]), 16'h1);
            if (n == AT_MRS) begin
                chk("R4", "mode ba", 16'(ba), 16'h0);
                chk("R4", "mode key", 16'(addr), 16'h02A);
            end
            if (n == AT_EMRS) begin
                chk("R5", "ext ba", 16'(ba), 16'h2);
                chk("R8", "ext key keeps init setting", 16'(addr), 16'h001);
            end
            if (n == 40) begin
                upd_req = 1'b1; upd_drive_half = 1'b1; upd_pasr = 2'd2;
            end
            if (n == 41) upd_req = 1'b0;
        end
    endtask

    task automatic t_hold_while_busy();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R8", "no load while banks busy", 16'(pins()), 16'h7);
            chk("R6", "ready held", 16'(ready), 16'h1);
        end
    endtask

    task automatic t_update_when_idle();
        banks_idle = 1'b1;
        @(negedge clk);
        chk("R7", "update load cmd", 16'(pins()), 16'h0);
        chk("R7", "update ba", 16'(ba), 16'h2);
        chk("R7", "update key", 16'(addr), 16'h022);
        for (int i = 0; i < TMRD + 5; i++) begin
            @(negedge clk);
            chk("R10", "nop after update", 16'(pins()), 16'h7);
            chk("R6", "ready during update", 16'(ready), 16'h1);
        end
    endtask

    task automatic t_update_live();
        upd_req = 1'b1; upd_drive_half = 1'b0; upd_pasr = 2'd0;
        @(negedge clk);
        upd_req = 1'b0; upd_drive_half = 1'b1; upd_pasr = 2'd3;
        chk("R7", "one cycle to latch", 16'(pins()), 16'h7);
        @(negedge clk);
        chk("R7", "live update cmd", 16'(pins()), 16'h0);
        chk("R7", "live update key", 16'(addr), 16'h000);
        repeat (TMRD + 1) @(negedge clk);
        chk("R10", "idle after live update", 16'(pins()), 16'h7);
    endtask

    task automatic t_reset_again();
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "ready cleared by reset", 16'(ready), 16'h0);
        chk("R1", "nop in reset", 16'(pins()), 16'h7);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R1", "wait restarts", 16'(pins()), 16'h7);
            chk("R9", "cke after reset", 16'(cke), 16'h1);
        end
    endtask

    initial begin
        t_reset_state();
        t_power_up();
        t_hold_while_busy();
        t_update_when_idle();
        t_update_live();
        t_reset_again();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule